// File: doc/BRIEF.md
# Grouped Direction Digital I/O Port

This block is an 8-pin general-purpose digital port reached through one 16-bit register on a simple word-wide bus. The low byte of the register holds the value the port drives on its pins. Reading the register returns the level of each pin. Two flag bits in the upper byte of the same register set the direction. Each flag covers a group of four pins: one group is pins 0 to 3 and the other is pins 4 to 7. A group whose flag is set drives its pins. A group whose flag is clear leaves its pins as inputs.

Each pin has a separate input, output value and output enable. Pad cells outside the block combine these into a bidirectional pin. Software keeps a copy of the register and updates it with a masked read-modify-write. The block therefore stores the whole value on each write and does nothing beyond that. For an output group, the read value is taken from the driven latch. For an input group, it is taken from the external level after a two-flop synchronizer.

Top module: `gdio_port`

## Requirements
- R1: After reset, every output enable is low, every driven value is zero, and the read data bus is zero.
- R2: A write with the address equal to 0x0A loads write-data bits 7:0 into the output latch. `pinOut` shows the new value from the clock edge that accepts the write, whatever the direction of each group.
- R3: Write-data bit 10 sets the direction of pins 3:0 and bit 11 sets the direction of pins 7:4 (1 = output, 0 = input). The change takes effect on `pinOe` at the accepting edge, and all four pins of a group always share one enable value.
- R4: A read at address 0x0A returns data on `busRdata` in the cycle after the read is accepted. The pin read-back is in bits 7:0 and the two direction flags are in bits 11:10.
- R5: For a pin in an output group, the read-back bit equals the latched drive value.
- R6: For a pin in an input group, the read-back bit is the external level passed through two flops. A level present at the input at clock edge k is seen by a read accepted at edge k+2 or later, and not by an earlier read.
- R7: Register bits 9:8 and 15:12 store nothing and always read as zero.
- R8: A write to any address other than 0x0A changes neither the pins nor the register. A read at another address returns zero.
- R9: In every cycle that does not follow an accepted read at 0x0A, `busRdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| busWrEn | input | 1 | Write request for this cycle |
| busRdEn | input | 1 | Read request for this cycle |
| busAddr | input | 6 | Byte address of the access |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, valid in the cycle after the read |
| pinIn | input | 8 | External pin levels (asynchronous) |
| pinOut | output | 8 | Value driven on each pin |
| pinOe | output | 8 | Output enable for each pin |

## Verification
A write shows on `pinOut` and `pinOe` right after the edge that accepts it. The bench therefore drives each access half a cycle before that edge and checks the pins half a cycle after it. Read data belongs to the cycle after the accepting edge, and it is sampled at the falling edge inside that cycle. An input-pin change is only counted as visible to a read accepted two edges after the level was sampled. The bench tests this by reading in three back-to-back cycles after a change and expects the old, old and then new value. A behavioural model updated on each rising edge, with a queue of the sampled pin levels, gives the expected value of every output on every cycle.

// File: rtl/gdio_pkg.sv
package gdio_pkg;
  // Strobes passed from the address decode to the datapath
  typedef struct packed {
    logic wrPort;  // accepted write to the port register
    logic rdPort;  // accepted read of the port register
  } gdioStrobe_t;
endpackage

// File: rtl/gdio_ctrl.sv
module gdio_ctrl
  import gdio_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 6'h0A
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output gdioStrobe_t       strobe
);
  logic hit;

  assign hit           = (busAddr == PORT_ADDR);
  assign strobe.wrPort = busWrEn & hit;
  assign strobe.rdPort = busRdEn & hit;
endmodule

// File: rtl/gdio_datapath.sv
module gdio_datapath
  import gdio_pkg::*;
#(
  parameter int PIN_COUNT  = 8,
  parameter int GROUP_SIZE = 4,
  parameter int DATA_W     = 16,
  parameter int DIR_LSB    = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  gdioStrobe_t          strobe,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe
);
  localparam int GROUP_COUNT = PIN_COUNT / GROUP_SIZE;

  logic [PIN_COUNT-1:0]   latchQ;
  logic [GROUP_COUNT-1:0] dirQ;
  logic [PIN_COUNT-1:0]   syncA;
  logic [PIN_COUNT-1:0]   syncB;
  logic [PIN_COUNT-1:0]   readBack;
  logic [DATA_W-1:0]      regView;

  // Drive latch and direction flags, whole-word store
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      latchQ <= '0;
      dirQ   <= '0;
    end else if (strobe.wrPort) begin
      latchQ <= busWdata[PIN_COUNT-1:0];
      dirQ   <= busWdata[DIR_LSB +: GROUP_COUNT];
    end
  end

  // Two-flop synchronizer on the external levels
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  // Per-group enable fan-out and read-back selection
  for (genvar g = 0; g < GROUP_COUNT; g++) begin : gGroup
    assign pinOe[g*GROUP_SIZE +: GROUP_SIZE] = {GROUP_SIZE{dirQ[g]}};
    assign readBack[g*GROUP_SIZE +: GROUP_SIZE] = dirQ[g] ?
        latchQ[g*GROUP_SIZE +: GROUP_SIZE] : syncB[g*GROUP_SIZE +: GROUP_SIZE];
  end

  assign pinOut = latchQ;

  // Unused bits are tied to zero here
  always_comb begin
    regView = '0;
    regView[PIN_COUNT-1:0] = readBack;
    regView[DIR_LSB +: GROUP_COUNT] = dirQ;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                busRdata <= '0;
    else if (strobe.rdPort) busRdata <= regView;
    else                    busRdata <= '0;
  end
endmodule

// File: rtl/gdio_port.sv
module gdio_port
  import gdio_pkg::*;
#(
  parameter int PIN_COUNT  = 8,
  parameter int GROUP_SIZE = 4,
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 6,
  parameter int DIR_LSB    = 10,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 6'h0A
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe
);
  gdioStrobe_t strobe;

  gdio_ctrl #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) uCtrl (
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .busAddr(busAddr),
    .strobe (strobe)
  );

  gdio_datapath #(
    .PIN_COUNT (PIN_COUNT),
    .GROUP_SIZE(GROUP_SIZE),
    .DATA_W    (DATA_W),
    .DIR_LSB   (DIR_LSB)
  ) uData (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .pinIn   (pinIn),
    .pinOut  (pinOut),
    .pinOe   (pinOe)
  );
endmodule

// File: rtl/gdio_port_chk.sv
module gdio_port_chk (
  input logic        clk,
  input logic        rst,
  input logic        busWrEn,
  input logic        busRdEn,
  input logic [5:0]  busAddr,
  input logic [15:0] busWdata,
  input logic [15:0] busRdata,
  input logic [7:0]  pinOut,
  input logic [7:0]  pinOe
);
  localparam logic [5:0] PORT_A = 6'h0A;

  a_r2_write_out: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && busAddr == PORT_A) |=> pinOut == $past(busWdata[7:0]));

  a_r3_dir_flags: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && busAddr == PORT_A) |=>
      (pinOe[0] == $past(busWdata[10])) && (pinOe[4] == $past(busWdata[11])));

  a_r3_group_shared: assert property (@(posedge clk) disable iff (rst)
    (pinOe[3:0] == 4'h0 || pinOe[3:0] == 4'hF) &&
    (pinOe[7:4] == 4'h0 || pinOe[7:4] == 4'hF));

  a_r7_unused_zero: assert property (@(posedge clk) disable iff (rst)
    busRdata[9:8] == 2'b00 && busRdata[15:12] == 4'h0);

  a_r8_other_write: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && busAddr != PORT_A) |=> $stable(pinOut) && $stable(pinOe));

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !(busRdEn && busAddr == PORT_A) |=> busRdata == 16'h0000);

  a_r4_flags_back: assert property (@(posedge clk) disable iff (rst)
    (busRdEn && busAddr == PORT_A) |=> busRdata[11:10] == {pinOe[4], pinOe[0]});
endmodule

bind gdio_port gdio_port_chk uChk (
  .clk     (clk),
  .rst     (rst),
  .busWrEn (busWrEn),
  .busRdEn (busRdEn),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .pinOut  (pinOut),
  .pinOe   (pinOe)
);

// File: tb/gdio_port_test.sv
`timescale 1ns/1ps
module gdio_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [5:0]  busAddr = 6'h00;
  logic [15:0] busWdata = 16'h0000;
  logic [15:0] busRdata;
  logic [7:0]  pinIn = 8'h00;
  logic [7:0]  pinOut;
  logic [7:0]  pinOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  gdio_port uut (
    .clk(clk), .rst(rst), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  // Behavioural reference model
  logic [7:0]  mLatch;
  logic [1:0]  mDir;
  logic [15:0] mRd;
  logic [7:0]  hist[$];

  always @(posedge clk or posedge rst) begin
    if (rst) begin
      mLatch = 8'h00; mDir = 2'b00; mRd = 16'h0000;
      hist.delete();
    end else begin
      logic [7:0] seen;
      logic [7:0] rb;
      seen = (hist.size() >= 2) ? hist[hist.size()-2] : 8'h00;
      for (int i = 0; i < 8; i++) rb[i] = mDir[i/4] ? mLatch[i] : seen[i];
      mRd = (busRdEn && busAddr == 6'h0A) ? {4'h0, mDir, 2'b00, rb} : 16'h0000;
      if (busWrEn && busAddr == 6'h0A) begin
        mLatch = busWdata[7:0];
        mDir   = busWdata[11:10];
      end
      hist.push_back(pinIn);
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model every cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 pinOut model", {8'h00, pinOut}, {8'h00, mLatch});
      check("R3 pinOe model", {8'h00, pinOe}, {8'h00, {4{mDir[1]}}, {4{mDir[0]}}});
      check("R4 busRdata model", busRdata, mRd);
    end
  end

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  // Issue a read; data is sampled at the falling edge after acceptance
  task automatic rd(logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdata;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset pinOe", {8'h00, pinOe}, 16'h0000);
    check("R1 reset pinOut", {8'h00, pinOut}, 16'h0000);
    check("R1 reset rdata", busRdata, 16'h0000);

    // Reserved bits set, both groups input
    wr(6'h0A, 16'hF3A5);
    check("R2 latch while input", {8'h00, pinOut}, 16'h00A5);
    pinIn = 8'h3C;
    repeat (3) @(negedge clk);
    rd(6'h0A, d);
    check("R6/R7 input readback", d, 16'h003C);

    // Low group output, high group input
    wr(6'h0A, 16'h04A5);
    check("R3 low group out", {8'h00, pinOe}, 16'h000F);
    rd(6'h0A, d);
    check("R5 mixed readback", d, 16'h0435);

    // Both groups output
    wr(6'h0A, 16'h0C5A);
    check("R3 both out", {8'h00, pinOe}, 16'h00FF);
    rd(6'h0A, d);
    check("R5 latch readback", d, 16'h0C5A);

    // Other address is ignored
    wr(6'h08, 16'h0000);
    check("R8 write elsewhere pinOut", {8'h00, pinOut}, 16'h005A);
    check("R8 write elsewhere pinOe", {8'h00, pinOe}, 16'h00FF);
    rd(6'h08, d);
    check("R8 read elsewhere", d, 16'h0000);
    @(negedge clk);
    check("R9 idle rdata", busRdata, 16'h0000);

    // Synchronizer latency with both groups input
    wr(6'h0A, 16'h0000);
    repeat (3) @(negedge clk);
    @(negedge clk);
    pinIn = 8'hC3; busRdEn = 1'b1; busAddr = 6'h0A;
    @(negedge clk);
    check("R6 read at edge k", busRdata, 16'h003C);
    @(negedge clk);
    check("R6 read at edge k+1", busRdata, 16'h003C);
    @(negedge clk);
    busRdEn = 1'b0;
    check("R6 read at edge k+2", busRdata, 16'h00C3);
    @(negedge clk);
    check("R9 after read", busRdata, 16'h0000);

    // High group output only
    wr(6'h0A, 16'h08F0);
    rd(6'h0A, d);
    check("R5 high group out", d, 16'h08F3);
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule